// File: doc/BRIEF.md
# Strobed Parallel Printer Output Port

This block is the host side of a character printer connection. Software does not toggle a strobe pin of its own. Instead, the top bit of every byte it writes is a software strobe. Each character goes out as three writes of the same 7-bit code: first with the strobe bit set, then with it clear, then with it set again. The port takes the character from the strobe-clear write. It then drives the 7-bit code onto the printer data lines together with a single-cycle hardware strobe pulse.

Every write makes the port busy. Busy stays set until the printer returns an acknowledge pulse. A status read gives a byte that is all ones while busy. When the port is idle, bit 5 is low and every other bit is high. Every write also sets a sticky sense flag. A carriage return written with the strobe clear is dropped and never reaches the printer. A strobe-clear write counts only once a strobe-set write has armed the port, so repeated writes cannot print a character twice.

Top module: `prt_strobe_port`

## Requirements
- R1: After reset, `pr_stb` is 0, `pr_data` is 0, `sense_flag` is 0 and the port is not busy, so `status_byte` reads 8'hDF.
- R2: When the port is armed, a write with bit 7 clear and a code in bits 6:0 other than 7'h0D drives that code onto `pr_data`. In the cycle after the write's clock edge, `pr_stb` is 1 for exactly one cycle.
- R3: A write with bit 7 set never raises `pr_stb` and leaves `pr_data` unchanged. It arms the port, and repeated set-bit writes still arm it only once.
- R4: A write with bit 7 clear while the port is not armed gives no pulse and leaves `pr_data` unchanged. The port is unarmed after reset and after any bit-7-clear write.
- R5: A write of 8'h0D (carriage return with bit 7 clear) gives no pulse and leaves `pr_data` unchanged, even when the port is armed. It still disarms the port.
- R6: Any write sets busy from the next cycle on, even when `pr_ack` is high in the same cycle.
- R7: A cycle with `pr_ack` high and no write clears busy from the next cycle on.
- R8: `status_byte` is 8'hFF while busy. It is 8'hDF while not busy: bit 5 low means ready, and all other bits read 1.
- R9: Any write sets `sense_flag` from the next cycle on, and it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe from the host bus |
| wr_byte | input | 8 | Written byte: bit 7 is the software strobe, bits 6:0 are the character |
| status_byte | output | 8 | Status read value: 8'hFF busy, 8'hDF ready |
| sense_flag | output | 1 | Sticky flag, set by any write |
| pr_data | output | 7 | Character presented to the printer |
| pr_stb | output | 1 | One-cycle printer strobe |
| pr_ack | input | 1 | Printer acknowledge pulse |

## Verification
The assertions assume that a write lasts one clock cycle and that its byte is valid in that cycle. They also assume that an acknowledge is a pulse, which may land in the same cycle as a write. The bench changes every input half a cycle away from the active edge. It holds each write and each acknowledge for a single cycle and leaves idle cycles between writes, so all of these assumptions hold. The stimulus covers every 7-bit code in the three-write pattern. It also includes out-of-order strobe sequences and an acknowledge that collides with a write.

// File: rtl/prt_pkg.sv
package prt_pkg;
    localparam int BYTE_W    = 8;
    localparam int CHAR_W    = BYTE_W - 1;
    localparam int STB_BIT   = BYTE_W - 1;
    localparam int READY_BIT = 5;
    localparam logic [CHAR_W-1:0] CR_CODE = 7'h0D;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_HIGH = 2'd1,
        WR_LOW  = 2'd2
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e          kind;
        logic [CHAR_W-1:0] code;
    } wr_cmd_t;

    function automatic wr_cmd_t classify(input logic en, input logic [BYTE_W-1:0] b);
        wr_cmd_t c;
        c.code = b[CHAR_W-1:0];
        if (!en)            c.kind = WR_IDLE;
        else if (b[STB_BIT]) c.kind = WR_HIGH;
        else                c.kind = WR_LOW;
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] status_code(input logic busy);
        logic [BYTE_W-1:0] s;
        s = '1;
        if (!busy) s[READY_BIT] = 1'b0;
        return s;
    endfunction
endpackage

// File: rtl/prt_write_decode.sv
module prt_write_decode
    import prt_pkg::*;
(
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output wr_cmd_t           cmd
);
    always_comb cmd = classify(wr_en, wr_byte);
endmodule

// File: rtl/prt_char_capture.sv
module prt_char_capture
    import prt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    output logic [CHAR_W-1:0] pr_data,
    output logic              pr_stb
);
    logic armed;
    logic fire;

    always_comb fire = (cmd.kind == WR_LOW) && armed && (cmd.code != CR_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            pr_data <= '0;
            pr_stb  <= 1'b0;
        end else begin
            pr_stb <= fire;
            if (fire) pr_data <= cmd.code;
            if (cmd.kind == WR_HIGH)     armed <= 1'b1;
            else if (cmd.kind == WR_LOW) armed <= 1'b0;
        end
    end

    // R2: a pulse only follows a strobe-clear write
    assert_pulse_from_low_R2: assert property (@(posedge clk) disable iff (rst)
        pr_stb |-> $past(cmd.kind == WR_LOW));
    // R5: carriage return never reaches the printer
    assert_no_cr_R5: assert property (@(posedge clk) disable iff (rst)
        pr_stb |-> (pr_data != CR_CODE));
    // R3: no back-to-back pulses, one character per arming
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        pr_stb |=> !pr_stb);
    // R3: strobe-high write leaves the data lines alone
    assert_high_keeps_data_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == WR_HIGH) |=> $stable(pr_data));
endmodule

// File: rtl/prt_busy_track.sv
module prt_busy_track
    import prt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  logic              pr_ack,
    output logic              busy,
    output logic              sense_flag,
    output logic [BYTE_W-1:0] status_byte
);
    logic any_wr;
    always_comb any_wr = (cmd.kind != WR_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            sense_flag <= 1'b0;
        end else begin
            if (any_wr)      busy <= 1'b1;
            else if (pr_ack) busy <= 1'b0;
            if (any_wr) sense_flag <= 1'b1;
        end
    end

    always_comb status_byte = status_code(busy);

    // R6: a write always leaves the port busy
    assert_busy_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        any_wr |=> busy);
    // R7: acknowledge without write frees the port
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (pr_ack && !any_wr) |=> !busy);
    // R9: sense is sticky
    assert_sense_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        sense_flag |=> sense_flag);
    // R8: ready bit low exactly when idle
    assert_status_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (status_byte[READY_BIT] == busy) && ($countones(status_byte) >= BYTE_W - 1));
endmodule

// File: rtl/prt_strobe_port.sv
module prt_strobe_port
    import prt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] status_byte,
    output logic              sense_flag,
    output logic [CHAR_W-1:0] pr_data,
    output logic              pr_stb,
    input  logic              pr_ack
);
    wr_cmd_t cmd;
    logic    busy;

    prt_write_decode u_dec (
        .wr_en   (wr_en),
        .wr_byte (wr_byte),
        .cmd     (cmd)
    );

    prt_char_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .pr_data (pr_data),
        .pr_stb  (pr_stb)
    );

    prt_busy_track u_busy (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .pr_ack      (pr_ack),
        .busy        (busy),
        .sense_flag  (sense_flag),
        .status_byte (status_byte)
    );

    // R6: the status byte follows a write into the busy code
    assert_status_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (status_byte == 8'hFF));
endmodule

// File: tb/test_prt_strobe_port.sv
module test_prt_strobe_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       pr_ack = 1'b0;
    logic [7:0] status_byte;
    logic       sense_flag;
    logic [6:0] pr_data;
    logic       pr_stb;

    int n_cmp = 0;
    int n_bad = 0;

    logic       m_armed = 1'b0;
    logic       m_busy = 1'b0;
    logic [6:0] m_data = 7'h00;

    always #2.5 clk = ~clk;

    prt_strobe_port i_prt_strobe_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
        .status_byte(status_byte), .sense_flag(sense_flag),
        .pr_data(pr_data), .pr_stb(pr_stb), .pr_ack(pr_ack)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one-cycle write; ack optionally in the same cycle
    task automatic put(input logic [7:0] b, input logic ack);
        logic fire;
        @(negedge clk);
        wr_en = 1'b1; wr_byte = b; pr_ack = ack;
        @(negedge clk);
        wr_en = 1'b0; pr_ack = 1'b0;
        fire = !b[7] && m_armed && (b[6:0] != 7'h0D);
        if (fire) m_data = b[6:0];
        m_armed = b[7];
        m_busy = 1'b1;
        if (b[7])                    check("R3 strobe", int'(pr_stb), 0);
        else if (b[6:0] == 7'h0D)    check("R5 strobe", int'(pr_stb), int'(fire));
        else if (fire)               check("R2 strobe", int'(pr_stb), 1);
        else                         check("R4 strobe", int'(pr_stb), 0);
        check("R2 data", int'(pr_data), int'(m_data));
        check("R6 status", int'(status_byte), 8'hFF);
        check("R9 sense", int'(sense_flag), 1);
        @(negedge clk);
        check("R2 one-cycle", int'(pr_stb), 0);
    endtask

    task automatic ack_pulse;
        @(negedge clk);
        pr_ack = 1'b1;
        @(negedge clk);
        pr_ack = 1'b0;
        m_busy = 1'b0;
        check("R7 busy clear", int'(status_byte), 8'hDF);
        check("R8 ready", int'(status_byte[5]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 stb", int'(pr_stb), 0);
        check("R1 data", int'(pr_data), 0);
        check("R1 sense", int'(sense_flag), 0);
        check("R1 status", int'(status_byte), 8'hDF);

        // R4: low write straight after reset is not armed
        put(8'h41, 1'b0);
        ack_pulse();

        // R2/R5: every code through the three-write pattern
        for (int c = 0; c < 128; c++) begin
            put(8'h80 | 8'(c), 1'b0);
            put(8'(c), 1'b0);
            put(8'h80 | 8'(c), 1'b0);
            check("R8 busy", int'(status_byte), 8'hFF);
            ack_pulse();
        end

        // R3: repeated high writes, then two lows give one character
        put(8'hD5, 1'b0);
        put(8'hD5, 1'b0);
        put(8'hD5, 1'b0);
        put(8'h55, 1'b0);
        put(8'h66, 1'b0);
        check("R4 second low", int'(pr_data), 8'h55);

        // R5: carriage return disarms; following low write does nothing
        put(8'h80, 1'b0);
        put(8'h0D, 1'b0);
        put(8'h22, 1'b0);
        check("R5 data kept", int'(pr_data), 8'h55);

        // R6: ack colliding with a write leaves busy
        ack_pulse();
        put(8'h90, 1'b1);
        check("R6 collision", int'(status_byte), 8'hFF);
        ack_pulse();
        check("R9 sticky", int'(sense_flag), 1);

        // R1: reset again restores the idle state
        put(8'h80, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 re-reset status", int'(status_byte), 8'hDF);
        check("R1 re-reset sense", int'(sense_flag), 0);
        check("R1 re-reset data", int'(pr_data), 0);
        m_armed = 1'b0; m_data = 7'h00;
        put(8'h30, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule